// File: doc/BRIEF.md
# DMA Burst Request Handshake Unit

This unit runs a single DMA channel that moves operands from an external peripheral into memory. Every operand takes two bus cycles: a read cycle from the peripheral, during which the acknowledge output `dack` is held high, then a write cycle to memory at an incrementing address. Each bus cycle walks through eight states, S0 to S7, one clock per state. The address strobe is high from S2 to S6. The cycle stalls in S4 until the slave answers with `dtack`.

The request input `dreq` is treated as a level and is captured on the falling clock edge. The value captured during S3 of the read cycle decides what happens after the operand. If it is high, the next operand starts straight after the write cycle and the bus is kept. If it is low, the bus is released and the unit waits, bus-idle, until the request is seen high again.

A block ends in one of four ways: the operand counter reaches zero, a bus error occurs, software aborts, or software starts a block with a zero length. The reason is latched in a four-bit status field that is cleared by writing ones. An interrupt is raised from that field under a global enable and two class enables.

Top module: `dma_burst_hs`

## Requirements
- R1: After reset, `bus_own`, `dack`, `bus_strobe`, `bus_write`, `status` and `irq` are all 0.
- R2: A `start` pulse with nonzero `blk_len` in the idle state begins a read cycle in the next clock. Each bus cycle lasts eight states, with `bus_strobe` high in S2 to S6. The read cycle (`dack`=1, `bus_write`=0) is followed by the write cycle (`dack`=0, `bus_write`=1). One operand with no wait states lasts 16 clocks.
- R3: In S4, while neither `dtack` nor `berr` is high, the cycle stays in S4 with the strobe held. Each such clock adds one clock to that bus cycle.
- R4: The `bus_rdata` value present when `dtack` is seen in S4 of the read cycle is driven on `bus_wdata` during the following write cycle. `bus_addr` during that write is `blk_base` plus the operand index, counting from 0.
- R5: `dreq` is captured on the falling clock edge. If the value captured during S3 of the read cycle is 1 and operands remain, S0 of the next read cycle follows write S7 directly, with `bus_own` staying high.
- R6: If the value captured during S3 is 0, `bus_own` falls after write S7 and stays low. The next operand starts only after `dreq` is captured high again.
- R7: The operand counter is loaded from `blk_len` and decrements once per operand. When the last operand ends, the block ends with status bit 0 (normal completion) set, whatever the level of `dreq`.
- R8: `berr` high in any clock while the bus is owned ends the block at that clock edge. Status bit 1 is set and `bus_own` is 0 in the next clock.
- R9: `abort` in the released (parked) state ends the block at once with status bit 2. An `abort` during an operand lets that operand finish, then ends the block with status bit 2.
- R10: A `start` with `blk_len`=0 sets status bit 3 and runs no bus cycle.
- R11: A `start` while a block is in progress is ignored. The block keeps its own length and addresses.
- R12: Writing a 1 to a bit of `stat_clr` clears that status bit. A status bit set in the same clock as its clear stays set.
- R13: `irq` = `ie_glob` & ((`ie_norm` & status[0]) | (`ie_err` & (status[1] | status[2] | status[3]))). It follows the status and the enables with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start a block (honoured when idle) |
| blk_len | input | CNT_W | Operand count of the block |
| blk_base | input | ADDR_W | First memory write address |
| abort | input | 1 | Software abort request |
| dreq | input | 1 | Level-sensitive peripheral request |
| dtack | input | 1 | Slave data acknowledge |
| berr | input | 1 | Bus error |
| bus_rdata | input | DATA_W | Read data from the peripheral |
| ie_glob | input | 1 | Global interrupt enable |
| ie_norm | input | 1 | Normal-completion interrupt enable |
| ie_err | input | 1 | Error/abort interrupt enable |
| stat_clr | input | 4 | Write-one-to-clear strobes for status |
| dack | output | 1 | Peripheral acknowledge (read cycle) |
| bus_own | output | 1 | Unit holds the bus |
| bus_strobe | output | 1 | Address strobe (S2 to S6) |
| bus_write | output | 1 | Current cycle is the memory write |
| bus_addr | output | ADDR_W | Memory write address |
| bus_wdata | output | DATA_W | Memory write data |
| status | output | 4 | Termination reasons: 0 done, 1 bus error, 2 abort, 3 zero length |
| irq | output | 1 | Block-end interrupt |

## Verification
The hardest case to reach is the single clock where the burst decision is made. `dreq` must fall exactly in S3 of the read cycle to end the burst, while falling one clock later, in S4, must still give a continuous second operand. The bench finds S0 from the rising edge of `dack` and counts clocks from there. It lowers `dreq` in S3 for one run and in S4 for another. For each run it checks the bus-owned clock count and whether the unit parks. The parked state is reached the same way, and `abort` is then applied to it, separately from an abort made in the middle of an operand.

// File: rtl/dbh_pkg.sv
package dbh_pkg;
  typedef enum logic [1:0] {M_IDLE, M_RUN, M_PARK} mode_t;

  localparam int ST_W     = 4;
  localparam int ST_DONE  = 0;
  localparam int ST_BERR  = 1;
  localparam int ST_ABORT = 2;
  localparam int ST_ZERO  = 3;

  localparam logic [2:0] S_STRB_ON  = 3'd2;
  localparam logic [2:0] S_SAMPLE   = 3'd3;
  localparam logic [2:0] S_ACK      = 3'd4;
  localparam logic [2:0] S_STRB_OFF = 3'd6;
  localparam logic [2:0] S_LAST     = 3'd7;
endpackage

// File: rtl/dbh_req_sample.sv
module dbh_req_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  output logic req_q
);
  // request level captured half a cycle ahead of the state register
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_in;
  end
endmodule

// File: rtl/dbh_bus_seq.sv
module dbh_bus_seq
  import dbh_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              chain,
  input  logic              dtack,
  input  logic              berr,
  input  logic              req_s,
  input  logic [DATA_W-1:0] rdata,
  output logic              active,
  output logic              wr_phase,
  output logic              strobe,
  output logic              ack_out,
  output logic              keep,
  output logic              op_end,
  output logic              err_end,
  output logic [DATA_W-1:0] wdata
);
  logic              act_q, wr_q, keep_q;
  logic [2:0]        s_q;
  logic [DATA_W-1:0] data_q;
  logic              at_ack, stall;

  assign at_ack  = act_q && (s_q == S_ACK);
  assign stall   = at_ack && !dtack;
  assign err_end = act_q && berr;
  assign op_end  = act_q && !berr && wr_q && (s_q == S_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      s_q   <= 3'd0;
    end else if (!act_q) begin
      if (go) begin
        act_q <= 1'b1;
        wr_q  <= 1'b0;
        s_q   <= 3'd0;
      end
    end else if (berr) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      s_q   <= 3'd0;
    end else if (!stall) begin
      if (s_q == S_LAST) begin
        s_q <= 3'd0;
        if (!wr_q) begin
          wr_q <= 1'b1;
        end else begin
          wr_q  <= 1'b0;
          act_q <= chain;
        end
      end else begin
        s_q <= s_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (act_q && !wr_q && (s_q == S_SAMPLE)) keep_q <= req_s;
      if (at_ack && dtack && !wr_q && !berr)   data_q <= rdata;
    end
  end

  assign active   = act_q;
  assign wr_phase = wr_q;
  assign strobe   = act_q && (s_q >= S_STRB_ON) && (s_q <= S_STRB_OFF);
  assign ack_out  = act_q && !wr_q;
  assign keep     = keep_q;
  assign wdata    = data_q;

  // R3: a missing data acknowledge holds the cycle in S4
  a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && s_q == S_ACK && !dtack && !berr) |=> (act_q && s_q == S_ACK && $stable(wr_q)));

  // R2: the read cycle's last state hands over to write S0
  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !wr_q && s_q == S_LAST && !berr) |=> (act_q && wr_q && s_q == 3'd0));

  // R8: a bus error drops bus ownership on the next clock
  a_r8_berr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && berr) |=> !act_q);
endmodule

// File: rtl/dbh_blk_ctrl.sv
module dbh_blk_ctrl
  import dbh_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  len,
  input  logic [ADDR_W-1:0] base,
  input  logic              abort,
  input  logic              req_s,
  input  logic              op_end,
  input  logic              err_end,
  input  logic              keep,
  output logic              go,
  output logic              chain,
  output mode_t             mode,
  output logic [ADDR_W-1:0] addr,
  output logic [ST_W-1:0]   set_vec
);
  mode_t             mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              abort_q;
  logic              last, abort_now, len_zero;

  assign last      = (cnt_q == CNT_W'(1));
  assign abort_now = abort_q || abort;
  assign len_zero  = (len == '0);
  assign chain     = keep && !last && !abort_now;
  assign go        = ((mode_q == M_IDLE) && start && !len_zero) ||
                     ((mode_q == M_PARK) && req_s && !abort);

  always_comb begin
    set_vec           = '0;
    set_vec[ST_ZERO]  = (mode_q == M_IDLE) && start && len_zero;
    set_vec[ST_DONE]  = (mode_q == M_RUN) && op_end && last;
    set_vec[ST_BERR]  = (mode_q == M_RUN) && err_end;
    set_vec[ST_ABORT] = ((mode_q == M_RUN) && op_end && !last && abort_now) ||
                        ((mode_q == M_PARK) && abort);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      unique case (mode_q)
        M_IDLE: begin
          if (start && !len_zero) begin
            cnt_q   <= len;
            addr_q  <= base;
            abort_q <= 1'b0;
            mode_q  <= M_RUN;
          end
        end
        M_RUN: begin
          if (abort) abort_q <= 1'b1;
          if (err_end) begin
            mode_q <= M_IDLE;
          end else if (op_end) begin
            cnt_q  <= cnt_q - CNT_W'(1);
            addr_q <= addr_q + ADDR_W'(1);
            if (last || abort_now) mode_q <= M_IDLE;
            else if (!keep)        mode_q <= M_PARK;
          end
        end
        M_PARK: begin
          if (abort)      mode_q <= M_IDLE;
          else if (req_s) mode_q <= M_RUN;
        end
        default: mode_q <= M_IDLE;
      endcase
    end
  end

  assign mode = mode_q;
  assign addr = addr_q;

  // R7: each finished operand that is not the last takes exactly one count
  a_r7_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && op_end && !last) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R7: the last operand always returns to idle
  a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && op_end && last) |=> (mode_q == M_IDLE));

  // R11: a start inside a running block leaves count and address alone
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && start && !op_end && !err_end) |=> ($stable(cnt_q) && $stable(addr_q)));
endmodule

// File: rtl/dbh_status_irq.sv
module dbh_status_irq
  import dbh_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_vec,
  input  logic [ST_W-1:0] clr,
  input  logic            ie_glob,
  input  logic            ie_norm,
  input  logic            ie_err,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic [ST_W-1:0] st_q;
  logic            norm_hit, err_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr) | set_vec;
  end

  assign norm_hit = ie_norm && st_q[ST_DONE];
  assign err_hit  = ie_err && (st_q[ST_BERR] || st_q[ST_ABORT] || st_q[ST_ZERO]);
  assign irq      = ie_glob && (norm_hit || err_hit);
  assign status   = st_q;

  // R12: a cleared bit with no simultaneous set reads back as zero
  a_r12_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr != '0) |=> ((st_q & $past(clr)) == '0));

  // R12: a set beats a clear in the same clock
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((st_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/dma_burst_hs.sv
module dma_burst_hs
  import dbh_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  blk_len,
  input  logic [ADDR_W-1:0] blk_base,
  input  logic              abort,
  input  logic              dreq,
  input  logic              dtack,
  input  logic              berr,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              ie_glob,
  input  logic              ie_norm,
  input  logic              ie_err,
  input  logic [3:0]        stat_clr,
  output logic              dack,
  output logic              bus_own,
  output logic              bus_strobe,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [3:0]        status,
  output logic              irq
);
  logic            req_s, go, chain, keep, op_end, err_end, active, wr_phase;
  mode_t           mode;
  logic [ST_W-1:0] set_vec;

  dbh_req_sample u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_in (dreq),
    .req_q  (req_s)
  );

  dbh_bus_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .chain    (chain),
    .dtack    (dtack),
    .berr     (berr),
    .req_s    (req_s),
    .rdata    (bus_rdata),
    .active   (active),
    .wr_phase (wr_phase),
    .strobe   (bus_strobe),
    .ack_out  (dack),
    .keep     (keep),
    .op_end   (op_end),
    .err_end  (err_end),
    .wdata    (bus_wdata)
  );

  dbh_blk_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .len     (blk_len),
    .base    (blk_base),
    .abort   (abort),
    .req_s   (req_s),
    .op_end  (op_end),
    .err_end (err_end),
    .keep    (keep),
    .go      (go),
    .chain   (chain),
    .mode    (mode),
    .addr    (bus_addr),
    .set_vec (set_vec)
  );

  dbh_status_irq u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr     (stat_clr),
    .ie_glob (ie_glob),
    .ie_norm (ie_norm),
    .ie_err  (ie_err),
    .status  (status),
    .irq     (irq)
  );

  assign bus_own   = active;
  assign bus_write = wr_phase;

  // R6: while parked the bus is not held
  a_r6_park_released: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PARK) |-> !active);

  // R13: no status, no interrupt
  a_r13_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'd0) |-> !irq);

  // R5: the bus is only held while a block is running
  a_r5_own_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (mode == M_RUN));
endmodule

// File: tb/tb_dma_burst_hs.sv
module tb_dma_burst_hs;
  localparam int CW = 4, AW = 8, DW = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 0, abort = 0, dreq = 0, dtack = 0, berr = 0;
  logic          ie_glob = 0, ie_norm = 0, ie_err = 0;
  logic [CW-1:0] blk_len = '0;
  logic [AW-1:0] blk_base = '0;
  logic [DW-1:0] bus_rdata = '0;
  logic [3:0]    stat_clr = '0;
  logic          dack, bus_own, bus_strobe, bus_write, irq;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [3:0]    status;

  int total = 0, bad = 0;
  int wst = 0, scnt = 0, nr = 0, nw = 0, own_cyc = 0;
  logic pdack = 0, pwr = 0;
  logic [15:0] wlog [16];

  always #2.5 clk = ~clk;

  dma_burst_hs #(.CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len), .blk_base(blk_base),
    .abort(abort), .dreq(dreq), .dtack(dtack), .berr(berr), .bus_rdata(bus_rdata),
    .ie_glob(ie_glob), .ie_norm(ie_norm), .ie_err(ie_err), .stat_clr(stat_clr),
    .dack(dack), .bus_own(bus_own), .bus_strobe(bus_strobe), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status(status), .irq(irq)
  );

  // slave model: acknowledge after wst wait clocks in S4, data tagged by operand number
  always @(posedge clk) begin
    #1;
    if (bus_strobe) scnt = scnt + 1; else scnt = 0;
    dtack = (scnt >= 3 + wst);
    bus_rdata = DW'(8'h40 + nr);
  end

  // monitor
  always @(posedge clk) begin
    #4;
    if (bus_own) own_cyc = own_cyc + 1;
    if (dack && !pdack) nr = nr + 1;
    if (bus_write && !pwr && nw < 16) begin
      wlog[nw] = {bus_addr, bus_wdata};
      nw = nw + 1;
    end
    pdack = dack;
    pwr = bus_write;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, a, e);
    end
  endtask

  task automatic clr_mon();
    nr = 0; nw = 0; own_cyc = 0;
  endtask

  task automatic clear_status();
    stat_clr = 4'hF; tick(); stat_clr = 4'h0;
  endtask

  task automatic go_blk(input int len, input int base);
    blk_len = CW'(len); blk_base = AW'(base); start = 1; tick(); start = 0;
  endtask

  task automatic wait_status();
    for (int i = 0; i < 500 && status == 4'd0; i++) tick();
    tick();
  endtask

  task automatic irq_sweep(input logic [3:0] s);
    for (int c = 0; c < 8; c++) begin
      ie_glob = c[0]; ie_norm = c[1]; ie_err = c[2];
      #0.5;
      chk("R13 irq", irq, c[0] & ((c[1] & s[0]) | (c[2] & (|s[3:1]))));
    end
    ie_glob = 0; ie_norm = 0; ie_err = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    chk("R1 bus_own", bus_own, 0);
    chk("R1 dack", dack, 0);
    chk("R1 strobe", bus_strobe, 0);
    chk("R1 write", bus_write, 0);
    chk("R1 status", status, 0);
    ie_glob = 1; ie_norm = 1; ie_err = 1; #0.5;
    chk("R1 irq", irq, 0);
    ie_glob = 0; ie_norm = 0; ie_err = 0;

    // R2 first states of an operand
    clr_mon(); wst = 0; dreq = 1;
    go_blk(1, 8'h05);
    chk("R2 S0 dack", dack, 1);
    chk("R2 S0 strobe", bus_strobe, 0);
    tick(); tick();
    chk("R2 S2 strobe", bus_strobe, 1);
    wait_status();
    chk("R2 single operand cycles", own_cyc, 16);
    chk("R7 done status", status, 4'h1);
    irq_sweep(status);
    clear_status();

    // R2 R3 R4 R5 R7 sweep over length and wait states with request held
    for (int w = 0; w < 3; w++) begin
      for (int l = 1; l <= 5; l++) begin
        clr_mon(); wst = w; dreq = 1;
        go_blk(l, 16 * l);
        wait_status();
        chk("R3 R5 burst own cycles", own_cyc, l * (16 + 2 * w));
        chk("R7 operands", nw, l);
        chk("R7 status", status, 4'h1);
        for (int j = 0; j < l; j++)
          chk("R4 addr/data", wlog[j], {8'(16 * l + j), 8'(8'h41 + j)});
        clear_status();
      end
    end
    wst = 0;

    // R6 request dropped in S3: release after first operand
    clr_mon(); dreq = 1;
    go_blk(2, 8'h60);
    repeat (3) tick();
    dreq = 0;
    repeat (20) tick();
    chk("R6 released", bus_own, 0);
    chk("R6 one operand", nw, 1);
    chk("R6 no status", status, 0);
    dreq = 1;
    wait_status();
    chk("R6 resumed operands", nw, 2);
    chk("R6 addr second", wlog[1], {8'h61, 8'h42});
    chk("R7 status after resume", status, 4'h1);
    clear_status();

    // R5 request dropped in S4: sample in S3 was high, burst continues
    clr_mon(); dreq = 1;
    go_blk(2, 8'h70);
    repeat (4) tick();
    dreq = 0;
    wait_status();
    chk("R5 continuous own cycles", own_cyc, 32);
    chk("R7 done with dreq low", status, 4'h1);
    clear_status();

    // R8 bus error
    clr_mon(); dreq = 1;
    go_blk(2, 8'h10);
    tick(); tick();
    berr = 1; tick(); berr = 0;
    chk("R8 released", bus_own, 0);
    chk("R8 status", status, 4'h2);
    chk("R8 no write", nw, 0);
    irq_sweep(status);
    clear_status();

    // R9 abort during operand
    clr_mon(); dreq = 1;
    go_blk(3, 8'h20);
    repeat (4) tick();
    abort = 1; tick(); abort = 0;
    wait_status();
    chk("R9 run abort status", status, 4'h4);
    chk("R9 run abort operands", nw, 1);
    clear_status();

    // R9 abort while parked
    clr_mon(); dreq = 0;
    go_blk(3, 8'h30);
    repeat (25) tick();
    chk("R9 parked", bus_own, 0);
    chk("R9 parked status", status, 0);
    abort = 1; tick(); abort = 0;
    chk("R9 park abort status", status, 4'h4);
    irq_sweep(status);
    dreq = 1; repeat (10) tick();
    chk("R9 stays idle", bus_own, 0);
    chk("R9 operands", nw, 1);
    clear_status();

    // R11 start during block ignored
    clr_mon(); dreq = 1;
    go_blk(2, 8'h80);
    repeat (5) tick();
    blk_len = 4'd7; blk_base = 8'h20; start = 1; tick(); start = 0;
    wait_status();
    chk("R11 operands", nw, 2);
    chk("R11 second addr", wlog[1], {8'h81, 8'h42});
    clear_status();

    // R10 zero length
    clr_mon();
    go_blk(0, 8'h00);
    chk("R10 status", status, 4'h8);
    repeat (5) tick();
    chk("R10 no bus", own_cyc, 0);
    irq_sweep(status);

    // R12 set beats clear, then clear
    blk_len = '0; start = 1; stat_clr = 4'h8; tick(); start = 0; stat_clr = 4'h0;
    chk("R12 set wins", status, 4'h8);
    stat_clr = 4'h8; tick(); stat_clr = 4'h0;
    chk("R12 cleared", status, 4'h0);
    irq_sweep(status);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule